// File: doc/BRIEF.md
# Auxiliary System Control Registers

This block is a slave register bank on a simple single-cycle peripheral bus. It gathers the odd system-level controls of a board into one place:
- a configuration byte that enables the power-fail interrupt;
- a free diagnostic byte;
- a modem-control byte;
- a 16-bit diagnostic LED word;
- an auxiliary byte whose bit 1 fires a floppy terminal-count pulse;
- a power-down byte holding the sticky power-fail status;
- a system-control word that requests a system reset and remembers that it did so.

A write to a separate power-management location asks the CPU to halt.

A request is presented for one cycle on `bus_valid`, together with the following:
- a space select, which picks the main window, the auxiliary byte, the power-down byte or the power-management location;
- a transfer size;
- a 28-bit address;
- right-justified write data.

A write takes effect at the next clock edge. Every request output is a registered pulse one clock wide, which appears in the cycle after the write. Read data and its valid flag are registered and appear one cycle after the read request. The interrupt line follows the stored state directly.

Reset clears the working registers. It deliberately leaves the diagnostic byte and the reset-seen flag of the system-control word alone, so that software can read after a reset that it caused that reset.

Top module: `aux_sysctl_regs`

## Requirements
- R1: After reset, the configuration, auxiliary, modem-control, power-down and LED registers read 0. All request outputs and the interrupt are low.
- R2: In the main window (space 0) only address bits 27:16 select a register. The codes are 0x180 for configuration, 0x1A0 for diagnostic, 0x1B0 for modem control, 0x160 for LED and 0x1F0 for system control. Any other code reads 0 and a write to it changes nothing.
- R3: Size encoding is 0 for byte, 1 for halfword and 2 for word. The LED register accepts only halfword, the system-control register only word, and every other register only byte. Any other size is a write that is dropped and a read that returns 0.
- R4: A byte write to the auxiliary register (space 1) with bit 1 set drives `fd_tc_o` high for exactly the next cycle. The register stores the write data with bit 1 forced to 0.
- R5: A write to the power-down register (space 2) keeps only data bits 0 and 1 and preserves the status bit 5. If data bit 1 is set, status bit 5 is cleared. Bit 1 never reads back as 1, and bit 0 is stored as written.
- R6: A power-down write with data bit 0 set drives `pwr_off_req_o` high for exactly the next cycle.
- R7: The power-fail status (power-down bit 5) is updated only when `pwr_failing_i` changes. On a rise it becomes set if configuration bit 3 is 1 at that moment, and stays clear otherwise. On a fall it clears. Clearing configuration bit 3 later does not clear it.
- R8: `pf_irq_o` is high exactly while both the power-fail status and configuration bit 3 are set. It follows either change in the same cycle the register updates.
- R9: A word write at system-control offset 0 (address bits 1:0 = 0) with bit 0 set makes that register read 0x02 and pulses `sys_rst_req_o` for one cycle. A write with bit 0 clear does nothing. Reads at a nonzero offset return 0.
- R10: Reset does not change the diagnostic register or the system-control register.
- R11: Any write to the power-management location (space 3), of any size, pulses `cpu_halt_req_o` for one cycle. Reads there return 0.
- R12: A read request produces `rd_valid` and `rd_data` in the following cycle, and a write produces no `rd_valid`. The diagnostic, modem-control and LED registers read back what was last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_sel | input | 2 | Space: 0 main window, 1 auxiliary, 2 power-down, 3 power management |
| bus_size | input | 2 | Transfer size: 0 byte, 1 halfword, 2 word |
| bus_addr | input | 28 | Byte address within the space |
| bus_wdata | input | 32 | Right-justified write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Right-justified read data |
| pwr_failing_i | input | 1 | Supply is failing (synchronous) |
| pf_irq_o | output | 1 | Power-fail interrupt |
| fd_tc_o | output | 1 | Floppy terminal-count pulse |
| pwr_off_req_o | output | 1 | Power-off request pulse |
| sys_rst_req_o | output | 1 | System reset request pulse |
| cpu_halt_req_o | output | 1 | CPU halt request pulse |

## Verification
The assertions take `pwr_failing_i` and all bus inputs to be synchronous to `clk` and stable across the edge. They also take each pulse output to be caused by the write seen one cycle earlier. They hold that the interrupt can only be high when the failing input was high in the previous cycle, which relies on the input never being sampled through a synchronizer.

The stimulus changes inputs only on falling edges. It never issues two requests in adjacent cycles, and it changes `pwr_failing_i` only in cycles without a power-down write. The relative order of a same-cycle clear and input edge is therefore never exercised.

// File: rtl/aux_sysctl_pkg.sv
// Package: shared encodings for the auxiliary system control register bank.
// Assumes a bus that carries a space select and a transfer-size code.
package aux_sysctl_pkg;

    typedef enum logic [1:0] {
        SP_MAIN = 2'd0,
        SP_AUX  = 2'd1,
        SP_PDN  = 2'd2,
        SP_PMG  = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } size_e;

    // One flag per addressable target; at most one is set per request.
    typedef struct packed {
        logic cfg;
        logic diag;
        logic mdm;
        logic led;
        logic sys;
        logic aux;
        logic pdn;
        logic pmg;
    } hit_t;

endpackage

// File: rtl/aux_sysctl_decode.sv
// Module: aux_sysctl_decode
// Turns space, size and address into a one-hot target select.
// A target is selected only when the transfer size matches it and, for the
// multi-byte registers, when the offset inside the register is zero.
// Assumes: purely combinational; the caller qualifies with the request valid.
module aux_sysctl_decode
    import aux_sysctl_pkg::*;
#(
    parameter int ADDR_W    = 28,
    parameter int FIELD_LSB = 16,
    parameter int FIELD_W   = 12,
    parameter logic [FIELD_W-1:0] CODE_CFG  = 12'h180,
    parameter logic [FIELD_W-1:0] CODE_DIAG = 12'h1A0,
    parameter logic [FIELD_W-1:0] CODE_MDM  = 12'h1B0,
    parameter logic [FIELD_W-1:0] CODE_LED  = 12'h160,
    parameter logic [FIELD_W-1:0] CODE_SYS  = 12'h1F0
) (
    input  logic [1:0]        space,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    output hit_t              hit
);
    localparam int FIELD_MSB = FIELD_LSB + FIELD_W - 1;

    logic [FIELD_W-1:0] field;
    logic               is_byte;
    logic               is_half;
    logic               is_word;

    assign field   = addr[FIELD_MSB:FIELD_LSB];
    assign is_byte = (size == SZ_BYTE);
    assign is_half = (size == SZ_HALF);
    assign is_word = (size == SZ_WORD);

    // Purpose: select the single target addressed by this request.
    always_comb begin
        hit = '0;
        unique case (space_e'(space))
            SP_MAIN: begin
                hit.cfg  = (field == CODE_CFG)  && is_byte;
                hit.diag = (field == CODE_DIAG) && is_byte;
                hit.mdm  = (field == CODE_MDM)  && is_byte;
                hit.led  = (field == CODE_LED)  && is_half && (addr[0] == 1'b0);
                hit.sys  = (field == CODE_SYS)  && is_word && (addr[1:0] == 2'b00);
            end
            SP_AUX:  hit.aux = is_byte;
            SP_PDN:  hit.pdn = is_byte;
            SP_PMG:  hit.pmg = 1'b1;
            default: hit = '0;
        endcase
    end

endmodule

// File: rtl/aux_sysctl_pwr.sv
// Module: aux_sysctl_pwr
// Holds the power-down byte: the stored power-off bit and the sticky
// power-fail status. Produces the interrupt and the power-off strobe.
// Assumes: fail_i is synchronous to clk; status changes only on an edge of
// fail_i or on a write-one clear; an input edge wins over a same-cycle clear.
module aux_sysctl_pwr #(
    parameter int REG_W    = 8,
    parameter int OFF_BIT  = 0,
    parameter int CLR_BIT  = 1,
    parameter int STAT_BIT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             enable_i,
    input  logic             fail_i,
    output logic [REG_W-1:0] value_o,
    output logic             irq_o,
    output logic             off_req_o
);
    logic fail_q;
    logic status_q;
    logic off_q;
    logic fail_edge;

    assign fail_edge = fail_i ^ fail_q;

    // Purpose: track the failing input to find its edges.
    always_ff @(posedge clk) begin
        if (!rst_n) fail_q <= 1'b0;
        else        fail_q <= fail_i;
    end

    // Purpose: update the sticky status and the stored power-off bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 1'b0;
            off_q    <= 1'b0;
        end else begin
            if (wr_i) begin
                off_q <= wdata_i[OFF_BIT];
                if (wdata_i[CLR_BIT]) status_q <= 1'b0;
            end
            if (fail_edge) status_q <= fail_i & enable_i;
        end
    end

    // Purpose: one-cycle power-off request after a write with the off bit.
    always_ff @(posedge clk) begin
        if (!rst_n) off_req_o <= 1'b0;
        else        off_req_o <= wr_i & wdata_i[OFF_BIT];
    end

    // Purpose: assemble the readable byte from the stored bits.
    always_comb begin
        value_o           = '0;
        value_o[OFF_BIT]  = off_q;
        value_o[STAT_BIT] = status_q;
    end

    assign irq_o = status_q & enable_i;

endmodule

// File: rtl/aux_sysctl_rdmux.sv
// Module: aux_sysctl_rdmux
// Selects read data from stored state and registers it with a valid flag.
// Assumes: hit is one-hot or zero; targets that are not selected read 0.
module aux_sysctl_rdmux
    import aux_sysctl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_W  = 8,
    parameter int LED_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  hit_t              hit,
    input  logic [REG_W-1:0]  cfg_i,
    input  logic [REG_W-1:0]  diag_i,
    input  logic [REG_W-1:0]  mdm_i,
    input  logic [REG_W-1:0]  aux_i,
    input  logic [REG_W-1:0]  pdn_i,
    input  logic [LED_W-1:0]  led_i,
    input  logic              sys_flag_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [DATA_W-1:0] sel_data;

    // Purpose: pick the addressed value, zero-extended to the bus width.
    always_comb begin
        sel_data = '0;
        if (hit.cfg)  sel_data[REG_W-1:0] = cfg_i;
        if (hit.diag) sel_data[REG_W-1:0] = diag_i;
        if (hit.mdm)  sel_data[REG_W-1:0] = mdm_i;
        if (hit.aux)  sel_data[REG_W-1:0] = aux_i;
        if (hit.pdn)  sel_data[REG_W-1:0] = pdn_i;
        if (hit.led)  sel_data[LED_W-1:0] = led_i;
        if (hit.sys)  sel_data[1]         = sys_flag_i;
    end

    // Purpose: register the read response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= rd_i;
            rd_data_o  <= rd_i ? sel_data : '0;
        end
    end

endmodule

// File: rtl/aux_sysctl_regs.sv
// Module: aux_sysctl_regs (top)
// Register bank for board-level controls: configuration, diagnostic, modem
// control, LED word, auxiliary byte, power-down byte, system-control word
// and a write-only power-management location. Emits single-cycle request
// strobes and a level power-fail interrupt.
// Assumes: one request per valid cycle; data right-justified on the bus;
// pwr_failing_i synchronous to clk.
module aux_sysctl_regs
    import aux_sysctl_pkg::*;
#(
    parameter int ADDR_W  = 28,
    parameter int DATA_W  = 32,
    parameter int REG_W   = 8,
    parameter int LED_W   = 16,
    parameter int EN_BIT  = 3,
    parameter int TC_BIT  = 1,
    parameter int RST_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [1:0]        bus_sel,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              pwr_failing_i,
    output logic              pf_irq_o,
    output logic              fd_tc_o,
    output logic              pwr_off_req_o,
    output logic              sys_rst_req_o,
    output logic              cpu_halt_req_o
);
    logic             wr;
    logic             rd;
    hit_t             hit;
    logic [REG_W-1:0] wbyte;
    logic [REG_W-1:0] cfg_q;
    logic [REG_W-1:0] diag_q;
    logic [REG_W-1:0] mdm_q;
    logic [REG_W-1:0] aux_q;
    logic [LED_W-1:0] led_q;
    logic             sys_flag_q;
    logic [REG_W-1:0] pdn_val;

    assign wr    = bus_valid & bus_write;
    assign rd    = bus_valid & ~bus_write;
    assign wbyte = bus_wdata[REG_W-1:0];

    aux_sysctl_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .space (bus_sel),
        .size  (bus_size),
        .addr  (bus_addr),
        .hit   (hit)
    );

    // Purpose: reset-cleared byte registers and LED word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            mdm_q <= '0;
            aux_q <= '0;
            led_q <= '0;
        end else if (wr) begin
            if (hit.cfg) cfg_q <= wbyte;
            if (hit.mdm) mdm_q <= wbyte;
            if (hit.aux) begin
                aux_q         <= wbyte;
                aux_q[TC_BIT] <= 1'b0;
            end
            if (hit.led) led_q <= bus_wdata[LED_W-1:0];
        end
    end

    // Purpose: registers that survive reset (diagnostic, reset-seen flag).
    always_ff @(posedge clk) begin
        if (wr && hit.diag) diag_q <= wbyte;
        if (wr && hit.sys && bus_wdata[RST_BIT]) sys_flag_q <= 1'b1;
    end

    // Purpose: one-cycle request strobes caused by writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fd_tc_o        <= 1'b0;
            sys_rst_req_o  <= 1'b0;
            cpu_halt_req_o <= 1'b0;
        end else begin
            fd_tc_o        <= wr & hit.aux & bus_wdata[TC_BIT];
            sys_rst_req_o  <= wr & hit.sys & bus_wdata[RST_BIT];
            cpu_halt_req_o <= wr & hit.pmg;
        end
    end

    aux_sysctl_pwr #(
        .REG_W (REG_W)
    ) u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr & hit.pdn),
        .wdata_i   (wbyte),
        .enable_i  (cfg_q[EN_BIT]),
        .fail_i    (pwr_failing_i),
        .value_o   (pdn_val),
        .irq_o     (pf_irq_o),
        .off_req_o (pwr_off_req_o)
    );

    aux_sysctl_rdmux #(
        .DATA_W (DATA_W),
        .REG_W  (REG_W),
        .LED_W  (LED_W)
    ) u_rdmux (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_i       (rd),
        .hit        (hit),
        .cfg_i      (cfg_q),
        .diag_i     (diag_q),
        .mdm_i      (mdm_q),
        .aux_i      (aux_q),
        .pdn_i      (pdn_val),
        .led_i      (led_q),
        .sys_flag_i (sys_flag_q),
        .rd_valid_o (rd_valid),
        .rd_data_o  (rd_data)
    );

endmodule

// File: rtl/aux_sysctl_checker.sv
// Module: aux_sysctl_checker
// Port-level properties of aux_sysctl_regs, attached by bind below.
// Assumes: the default parameter values of the top module.
module aux_sysctl_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_valid,
    input logic        bus_write,
    input logic [1:0]  bus_sel,
    input logic [1:0]  bus_size,
    input logic [27:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic        rd_valid,
    input logic [31:0] rd_data,
    input logic        pwr_failing_i,
    input logic        pf_irq_o,
    input logic        fd_tc_o,
    input logic        pwr_off_req_o,
    input logic        sys_rst_req_o,
    input logic        cpu_halt_req_o
);
    AST_TC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        fd_tc_o |-> $past(bus_valid && bus_write && bus_sel == 2'd1 && bus_size == 2'd0 && bus_wdata[1])); // R4
    AST_OFF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_off_req_o |-> $past(bus_valid && bus_write && bus_sel == 2'd2 && bus_size == 2'd0 && bus_wdata[0])); // R6
    AST_IRQ_NEEDS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        pf_irq_o |-> $past(pwr_failing_i)); // R8
    AST_SYSRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req_o |-> $past(bus_valid && bus_write && bus_sel == 2'd0 && bus_size == 2'd2
                                && bus_addr[27:16] == 12'h1F0 && bus_addr[1:0] == 2'b00 && bus_wdata[0])); // R9
    AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_halt_req_o |-> $past(bus_valid && bus_write && bus_sel == 2'd3)); // R11
    AST_PMG_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_sel == 2'd3) |=> (rd_valid && rd_data == 32'd0)); // R11
    AST_RDV_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(bus_valid && !bus_write)); // R12
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_sel == 2'd0 && bus_size == 2'd3) |=> (rd_data == 32'd0)); // R3
endmodule

bind aux_sysctl_regs aux_sysctl_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_valid      (bus_valid),
    .bus_write      (bus_write),
    .bus_sel        (bus_sel),
    .bus_size       (bus_size),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .rd_valid       (rd_valid),
    .rd_data        (rd_data),
    .pwr_failing_i  (pwr_failing_i),
    .pf_irq_o       (pf_irq_o),
    .fd_tc_o        (fd_tc_o),
    .pwr_off_req_o  (pwr_off_req_o),
    .sys_rst_req_o  (sys_rst_req_o),
    .cpu_halt_req_o (cpu_halt_req_o)
);

// File: tb/aux_sysctl_regs_test.sv
// Scoreboard bench: read tasks queue expected data, a monitor compares.
module aux_sysctl_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_sel = 2'd0;
    logic [1:0]  bus_size = 2'd0;
    logic [27:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        pwr_failing_i = 1'b0;
    logic        pf_irq_o;
    logic        fd_tc_o;
    logic        pwr_off_req_o;
    logic        sys_rst_req_o;
    logic        cpu_halt_req_o;

    int tests = 0;
    int fails = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    localparam logic [27:0] A_CFG  = 28'h180_0000;
    localparam logic [27:0] A_DIAG = 28'h1A0_0000;
    localparam logic [27:0] A_MDM  = 28'h1B0_0000;
    localparam logic [27:0] A_LED  = 28'h160_0000;
    localparam logic [27:0] A_SYS  = 28'h1F0_0000;

    always #2 clk = ~clk;

    aux_sysctl_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_sel(bus_sel), .bus_size(bus_size), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .pwr_failing_i(pwr_failing_i), .pf_irq_o(pf_irq_o), .fd_tc_o(fd_tc_o),
        .pwr_off_req_o(pwr_off_req_o), .sys_rst_req_o(sys_rst_req_o),
        .cpu_halt_req_o(cpu_halt_req_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [1:0] size,
                      input logic [27:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_sel = sel; bus_size = size;
        bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, input logic [1:0] size,
                      input logic [27:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_sel = sel; bus_size = size;
        bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    // Monitor: pop and compare each read response.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R12 unexpected rd_valid", 32'd1, 32'd0);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL watchdog R12 actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", {31'd0, pf_irq_o}, 32'd0);
        check("R1 strobes", {27'd0, fd_tc_o, pwr_off_req_o, sys_rst_req_o, cpu_halt_req_o, rd_valid}, 32'd0);
        rd(2'd0, 2'd0, A_CFG, 32'h00, "R1 cfg");
        rd(2'd1, 2'd0, 28'h0, 32'h00, "R1 aux");
        rd(2'd2, 2'd0, 28'h0, 32'h00, "R1 pdn");
        rd(2'd0, 2'd0, A_MDM, 32'h00, "R1 mdm");
        rd(2'd0, 2'd1, A_LED, 32'h00, "R1 led");

        // R12 readback, R2 low address bits ignored
        wr(2'd0, 2'd0, A_DIAG, 32'hA5);
        check("R12 no rd_valid on write", {31'd0, rd_valid}, 32'd0);
        wr(2'd0, 2'd0, A_MDM | 28'h00_FFFF, 32'h3C);
        wr(2'd0, 2'd1, A_LED, 32'hBEEF);
        rd(2'd0, 2'd0, A_DIAG, 32'hA5, "R12 diag");
        rd(2'd0, 2'd0, A_MDM, 32'h3C, "R2 mdm via high offset");
        rd(2'd0, 2'd1, A_LED, 32'hBEEF, "R12 led");

        // R2 unmapped
        wr(2'd0, 2'd0, 28'h170_0000, 32'hFF);
        rd(2'd0, 2'd0, 28'h170_0000, 32'h00, "R2 unmapped read");
        rd(2'd0, 2'd0, A_DIAG, 32'hA5, "R2 unmapped write no effect");

        // R3 size mismatches
        wr(2'd0, 2'd0, A_LED, 32'h1234);
        rd(2'd0, 2'd1, A_LED, 32'hBEEF, "R3 byte write to led dropped");
        rd(2'd0, 2'd2, A_DIAG, 32'h00, "R3 word read of diag");
        wr(2'd0, 2'd1, A_SYS, 32'h1);
        check("R3 half write to sys no strobe", {31'd0, sys_rst_req_o}, 32'd0);

        // R4 terminal count
        wr(2'd1, 2'd0, 28'h0, 32'h83);
        check("R4 tc pulse", {31'd0, fd_tc_o}, 32'd1);
        @(negedge clk);
        check("R4 tc one cycle", {31'd0, fd_tc_o}, 32'd0);
        rd(2'd1, 2'd0, 28'h0, 32'h81, "R4 aux stored without bit1");
        wr(2'd1, 2'd0, 28'h0, 32'h40);
        check("R4 no tc", {31'd0, fd_tc_o}, 32'd0);

        // R7/R8 power fail
        wr(2'd0, 2'd0, A_CFG, 32'h08);
        @(negedge clk); pwr_failing_i = 1'b1;
        @(negedge clk);
        check("R8 irq after rise", {31'd0, pf_irq_o}, 32'd1);
        rd(2'd2, 2'd0, 28'h0, 32'h20, "R7 status set");
        wr(2'd0, 2'd0, A_CFG, 32'h00);
        check("R8 irq follows enable", {31'd0, pf_irq_o}, 32'd0);
        rd(2'd2, 2'd0, 28'h0, 32'h20, "R7 sticky");
        wr(2'd0, 2'd0, A_CFG, 32'h08);
        check("R8 irq back", {31'd0, pf_irq_o}, 32'd1);
        // R5 preserve status, mask bits
        wr(2'd2, 2'd0, 28'h0, 32'hFC);
        rd(2'd2, 2'd0, 28'h0, 32'h20, "R5 preserve status");
        wr(2'd2, 2'd0, 28'h0, 32'h02);
        check("R5 clear drops irq", {31'd0, pf_irq_o}, 32'd0);
        rd(2'd2, 2'd0, 28'h0, 32'h00, "R5 cleared");
        // R7 fall then rise with enable off
        @(negedge clk); pwr_failing_i = 1'b0;
        wr(2'd0, 2'd0, A_CFG, 32'h00);
        @(negedge clk); pwr_failing_i = 1'b1;
        @(negedge clk);
        rd(2'd2, 2'd0, 28'h0, 32'h00, "R7 rise without enable");
        @(negedge clk); pwr_failing_i = 1'b0;
        wr(2'd0, 2'd0, A_CFG, 32'h08);
        @(negedge clk); pwr_failing_i = 1'b1;
        @(negedge clk);
        check("R8 irq second rise", {31'd0, pf_irq_o}, 32'd1);
        @(negedge clk); pwr_failing_i = 1'b0;
        @(negedge clk);
        check("R7 fall clears", {31'd0, pf_irq_o}, 32'd0);
        rd(2'd2, 2'd0, 28'h0, 32'h00, "R7 status after fall");

        // R11 power management
        wr(2'd3, 2'd2, 28'h0, 32'h0);
        check("R11 halt pulse", {31'd0, cpu_halt_req_o}, 32'd1);
        @(negedge clk);
        check("R11 halt one cycle", {31'd0, cpu_halt_req_o}, 32'd0);
        rd(2'd3, 2'd0, 28'h0, 32'h00, "R11 read zero");

        // R9 system control
        wr(2'd0, 2'd2, A_SYS, 32'h0);
        check("R9 bit0 clear no strobe", {31'd0, sys_rst_req_o}, 32'd0);
        wr(2'd0, 2'd2, A_SYS, 32'h1);
        check("R9 reset strobe", {31'd0, sys_rst_req_o}, 32'd1);
        @(negedge clk);
        check("R9 strobe one cycle", {31'd0, sys_rst_req_o}, 32'd0);
        rd(2'd0, 2'd2, A_SYS, 32'h02, "R9 reads 0x02");
        rd(2'd0, 2'd2, A_SYS | 28'h2, 32'h00, "R9 nonzero offset");

        // R10 reset keeps diag and sys; R1 clears others
        wr(2'd0, 2'd0, A_DIAG, 32'h5A);
        wr(2'd0, 2'd0, A_CFG, 32'h08);
        wr(2'd0, 2'd0, A_MDM, 32'h77);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(2'd0, 2'd0, A_DIAG, 32'h5A, "R10 diag kept");
        rd(2'd0, 2'd2, A_SYS, 32'h02, "R10 sys kept");
        rd(2'd0, 2'd0, A_CFG, 32'h00, "R1 cfg cleared");
        rd(2'd0, 2'd0, A_MDM, 32'h00, "R1 mdm cleared");
        rd(2'd1, 2'd0, 28'h0, 32'h00, "R1 aux cleared");

        // R6 power off (last: stored bit stays set)
        wr(2'd2, 2'd0, 28'h0, 32'h01);
        check("R6 off strobe", {31'd0, pwr_off_req_o}, 32'd1);
        @(negedge clk);
        check("R6 off one cycle", {31'd0, pwr_off_req_o}, 32'd0);
        rd(2'd2, 2'd0, 28'h0, 32'h01, "R5 off bit stored");

        repeat (3) @(negedge clk);
        check("R12 all reads answered", exp_q.size(), 32'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule